// File: doc/BRIEF.md
# Sixteen-Bit DSP Arithmetic/Logic Unit with Operand Registers

This block is the fixed-point arithmetic/logic stage of a DSP datapath. It holds a pair of X operand registers, a pair of Y operand registers, and a feedback register that keeps the last result. Per cycle, the X operand comes from one X register or from an external result bus shared with the other computational units. The Y operand comes from one Y register or from the feedback register. The unit executes one of fourteen operations and registers the 16-bit result together with six status flags at the clock edge.

A data bus can write any of the four operand registers, and it can read any of them through a registered read port. This bus access does not disturb the register that is currently feeding the ALU, so loads and stores overlap with computation. The stored carry flag is the carry input for add-with-carry. The stored quotient flag steers the division step, so a multi-cycle division is one sign step followed by repeated quotient steps, with the Y operand taken from the feedback register.

Top module: `dsp_alu_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the result register, all six flags and all four operand registers are cleared to zero. The bus read port also returns zero.
- R2: `x_sel` values 0 and 1 pick X register 0 and 1, and values 2 and 3 pick `rbus_in`. `y_sel` values 0 and 1 pick Y register 0 and 1, and values 2 and 3 pick the feedback register (the current `result`).
- R3: Opcode 0 gives X+Y and opcode 1 gives X+Y+C, where C is the stored carry. Opcode 2 gives X−Y and opcode 3 gives Y−X. Carry is the adder carry-out, so for subtraction it is 1 when no borrow occurs.
- R4: Opcode 4 gives −X, opcode 5 gives X+1 and opcode 6 gives X−1. Each one computes through the adder with the carry defined as in R3. For every opcode from 0 to 13, zero and negative reflect the new result.
- R5: For opcodes 0 to 6, overflow is set exactly when the two's-complement signed result does not fit in 16 bits.
- R6: Opcode 7 gives |X|. An X of 0x8000 returns 0x8000 with overflow set. Carry is cleared, and the sign flag takes bit 15 of X.
- R7: Opcodes 8, 9, 10 and 11 give X AND Y, X OR Y, X XOR Y and NOT X. They clear carry and overflow.
- R8: Opcode 12 (sign step) returns Y unchanged and sets the quotient flag to Y[15] XOR X[15]. It clears carry and overflow.
- R9: Opcode 13 (quotient step) forms {Y[14:0], Q}, where Q is the stored quotient flag. It adds X when Q is 1 and subtracts X when Q is 0. The quotient flag becomes bit 15 of that sum XOR X[15], and carry and overflow are cleared.
- R10: Result and flags change only at the clock edge that ends a cycle with `op_valid` high. When `op_valid` is low, or the opcode is 14 or 15, they hold their values.
- R11: `bus_wr_addr` values 0, 1, 2 and 3 write X0, X1, Y0 and Y1. `bus_rd_data` shows the register addressed by `bus_rd_addr` one cycle later, including during cycles in which an operation executes.
- R12: The quotient flag changes only on opcodes 12 and 13. The sign flag changes only on opcode 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Execute the operation this cycle |
| op_code | input | 4 | Operation code |
| x_sel | input | 2 | X operand source |
| y_sel | input | 2 | Y operand source |
| rbus_in | input | 16 | Shared result bus from other units |
| bus_wr_en | input | 1 | Data bus write strobe |
| bus_wr_addr | input | 2 | Operand register to write |
| bus_wr_data | input | 16 | Data bus write value |
| bus_rd_addr | input | 2 | Operand register to read |
| bus_rd_data | output | 16 | Registered read value |
| result | output | 16 | Result / feedback register |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| flag_s | output | 1 | X sign flag |
| flag_q | output | 1 | Quotient flag |

## Verification
The bench tests signed overflow at both ends of the range: 0x7FFF+1, 0x8000−1, increment of 0x7FFF, decrement of 0x8000 and negation of 0x8000. A design that tests overflow on unsigned carry, or on the raw Y operand instead of the inverted one, reports the wrong V flag on these vectors. Absolute value of 0x8000 and subtract carry polarity are checked too, because an inverted borrow silently breaks add-with-carry chains. The division steps are chained through the feedback register with both quotient polarities. This exposes a step that adds where it should subtract or shifts in the wrong bit. The sign and quotient flags are also checked so that they hold across unrelated operations and reserved opcodes.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBR = 4'd3,
    OP_NEG  = 4'd4,
    OP_INC  = 4'd5,
    OP_DEC  = 4'd6,
    OP_ABS  = 4'd7,
    OP_AND  = 4'd8,
    OP_OR   = 4'd9,
    OP_XOR  = 4'd10,
    OP_NOT  = 4'd11,
    OP_DSGN = 4'd12,
    OP_DSTP = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
    logic s;
    logic q;
  } alu_flags_t;

endpackage

// File: rtl/alu_operand_bank.sv
module alu_operand_bank #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 2,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [IW-1:0]    alu_idx,
  output logic [WIDTH-1:0] alu_data,
  input  logic [IW-1:0]    bus_idx,
  output logic [WIDTH-1:0] bus_data
);

  logic [WIDTH-1:0] regs [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= '0;
      end else if (wr_en && (wr_idx == IW'(g))) begin
        regs[g] <= wr_data;
      end
    end
  end

  // Two independent read ports: one for the ALU, one for the bus
  assign alu_data = regs[alu_idx];
  assign bus_data = regs[bus_idx];

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  alu_flags_t       cur,
  output logic [WIDTH-1:0] res,
  output alu_flags_t       nxt,
  output logic             legal
);

  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] add_a, add_b;
  logic             add_ci;
  logic [WIDTH:0]   add_sum;
  logic             add_v;
  logic [WIDTH-1:0] step_base;

  assign step_base = {y[MSB-1:0], cur.q};

  // Operand steering into the single shared adder
  always_comb begin
    add_a  = x;
    add_b  = y;
    add_ci = 1'b0;
    unique case (op)
      OP_ADD:  begin add_a = x; add_b = y;       add_ci = 1'b0;   end
      OP_ADDC: begin add_a = x; add_b = y;       add_ci = cur.c;  end
      OP_SUB:  begin add_a = x; add_b = ~y;      add_ci = 1'b1;   end
      OP_SUBR: begin add_a = y; add_b = ~x;      add_ci = 1'b1;   end
      OP_NEG,
      OP_ABS:  begin add_a = '0; add_b = ~x;     add_ci = 1'b1;   end
      OP_INC:  begin add_a = x; add_b = '0;      add_ci = 1'b1;   end
      OP_DEC:  begin add_a = x; add_b = '1;      add_ci = 1'b0;   end
      OP_DSTP: begin
        add_a  = step_base;
        add_b  = cur.q ? x : ~x;
        add_ci = ~cur.q;
      end
      default: begin add_a = x; add_b = y;       add_ci = 1'b0;   end
    endcase
  end

  assign add_sum = {1'b0, add_a} + {1'b0, add_b} + {{WIDTH{1'b0}}, add_ci};
  assign add_v   = (add_a[MSB] == add_b[MSB]) && (add_sum[MSB] != add_a[MSB]);

  always_comb begin
    res   = add_sum[MSB:0];
    nxt   = cur;
    legal = 1'b1;
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBR, OP_NEG, OP_INC, OP_DEC: begin
        res   = add_sum[MSB:0];
        nxt.c = add_sum[WIDTH];
        nxt.v = add_v;
      end
      OP_ABS: begin
        res   = x[MSB] ? add_sum[MSB:0] : x;
        nxt.c = 1'b0;
        nxt.v = (x == MOST_NEG);
        nxt.s = x[MSB];
      end
      OP_AND, OP_OR, OP_XOR, OP_NOT: begin
        case (op)
          OP_AND:  res = x & y;
          OP_OR:   res = x | y;
          OP_XOR:  res = x ^ y;
          default: res = ~x;
        endcase
        nxt.c = 1'b0;
        nxt.v = 1'b0;
      end
      OP_DSGN: begin
        res   = y;
        nxt.c = 1'b0;
        nxt.v = 1'b0;
        nxt.q = y[MSB] ^ x[MSB];
      end
      OP_DSTP: begin
        res   = add_sum[MSB:0];
        nxt.c = 1'b0;
        nxt.v = 1'b0;
        nxt.q = add_sum[MSB] ^ x[MSB];
      end
      default: begin
        legal = 1'b0;
      end
    endcase
    nxt.z = (res == '0);
    nxt.n = res[MSB];
  end

endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
  import alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] res_in,
  input  alu_flags_t       flags_in,
  output logic [WIDTH-1:0] res_q,
  output alu_flags_t       flags_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      flags_q <= '0;
    end else if (load) begin
      res_q   <= res_in;
      flags_q <= flags_in;
    end
  end

endmodule

// File: rtl/dsp_alu_unit.sv
module dsp_alu_unit
  import alu_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int REGS  = 2,
  localparam int IW = (REGS > 1) ? $clog2(REGS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [3:0]       op_code,
  input  logic [IW:0]      x_sel,
  input  logic [IW:0]      y_sel,
  input  logic [WIDTH-1:0] rbus_in,
  input  logic             bus_wr_en,
  input  logic [IW:0]      bus_wr_addr,
  input  logic [WIDTH-1:0] bus_wr_data,
  input  logic [IW:0]      bus_rd_addr,
  output logic [WIDTH-1:0] bus_rd_data,
  output logic [WIDTH-1:0] result,
  output logic             flag_z,
  output logic             flag_n,
  output logic             flag_c,
  output logic             flag_v,
  output logic             flag_s,
  output logic             flag_q
);

  logic [WIDTH-1:0] xreg_alu, xreg_bus, yreg_alu, yreg_bus;
  logic [WIDTH-1:0] x_opnd, y_opnd, core_res;
  alu_flags_t       flags_cur, flags_nxt;
  logic             core_legal;

  // Top address bit picks the bank (0 = X, 1 = Y)
  alu_operand_bank #(.WIDTH(WIDTH), .DEPTH(REGS)) u_xbank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bus_wr_en && !bus_wr_addr[IW]),
    .wr_idx   (bus_wr_addr[IW-1:0]),
    .wr_data  (bus_wr_data),
    .alu_idx  (x_sel[IW-1:0]),
    .alu_data (xreg_alu),
    .bus_idx  (bus_rd_addr[IW-1:0]),
    .bus_data (xreg_bus)
  );

  alu_operand_bank #(.WIDTH(WIDTH), .DEPTH(REGS)) u_ybank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bus_wr_en && bus_wr_addr[IW]),
    .wr_idx   (bus_wr_addr[IW-1:0]),
    .wr_data  (bus_wr_data),
    .alu_idx  (y_sel[IW-1:0]),
    .alu_data (yreg_alu),
    .bus_idx  (bus_rd_addr[IW-1:0]),
    .bus_data (yreg_bus)
  );

  assign x_opnd = x_sel[IW] ? rbus_in : xreg_alu;
  assign y_opnd = y_sel[IW] ? result  : yreg_alu;

  alu_core #(.WIDTH(WIDTH)) u_core (
    .op    (op_code),
    .x     (x_opnd),
    .y     (y_opnd),
    .cur   (flags_cur),
    .res   (core_res),
    .nxt   (flags_nxt),
    .legal (core_legal)
  );

  alu_status_reg #(.WIDTH(WIDTH)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .load     (op_valid && core_legal),
    .res_in   (core_res),
    .flags_in (flags_nxt),
    .res_q    (result),
    .flags_q  (flags_cur)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rd_data <= '0;
    end else begin
      bus_rd_data <= bus_rd_addr[IW] ? yreg_bus : xreg_bus;
    end
  end

  assign flag_z = flags_cur.z;
  assign flag_n = flags_cur.n;
  assign flag_c = flags_cur.c;
  assign flag_v = flags_cur.v;
  assign flag_s = flags_cur.s;
  assign flag_q = flags_cur.q;

endmodule

// File: rtl/dsp_alu_unit_checker.sv
module dsp_alu_unit_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic [3:0]       op_code,
  input logic [WIDTH-1:0] x_opnd,
  input logic [WIDTH-1:0] result,
  input logic             flag_z,
  input logic             flag_n,
  input logic             flag_c,
  input logic             flag_v,
  input logic             flag_s,
  input logic             flag_q
);

  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  logic rst_seen_q = 1'b0;
  always_ff @(posedge clk) rst_seen_q <= rst;

  // R1: a cycle after reset was sampled, everything is clear
  always @(posedge clk) begin
    if (rst_seen_q) begin
      a_r1_reset_clears: assert (result == '0 &&
        {flag_z, flag_n, flag_c, flag_v, flag_s, flag_q} == 6'b0);
    end
  end

  a_r4_zero_neg_track: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code < 4'd14) |=> (flag_z == (result == '0)) && (flag_n == result[WIDTH-1]));

  a_r6_abs_most_negative: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd7 && x_opnd == MOST_NEG) |=> (result == MOST_NEG) && flag_v && !flag_c);

  a_r7_logic_clears_cv: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code >= 4'd8 && op_code <= 4'd11) |=> !flag_c && !flag_v);

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || op_code >= 4'd14) |=>
      $stable(result) && $stable({flag_z, flag_n, flag_c, flag_v, flag_s, flag_q}));

  a_r12_quotient_holds: assert property (@(posedge clk) disable iff (rst)
    (op_code != 4'd12 && op_code != 4'd13) |=> $stable(flag_q));

  a_r12_sign_holds: assert property (@(posedge clk) disable iff (rst)
    (op_code != 4'd7) |=> $stable(flag_s));

endmodule

bind dsp_alu_unit dsp_alu_unit_checker #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_valid (op_valid),
  .op_code  (op_code),
  .x_opnd   (x_opnd),
  .result   (result),
  .flag_z   (flag_z),
  .flag_n   (flag_n),
  .flag_c   (flag_c),
  .flag_v   (flag_v),
  .flag_s   (flag_s),
  .flag_q   (flag_q)
);

// File: tb/sim_dsp_alu_unit.sv
`timescale 1ns/1ps
module sim_dsp_alu_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = 4'd0;
  logic [1:0]  x_sel = 2'd0;
  logic [1:0]  y_sel = 2'd0;
  logic [15:0] rbus_in = 16'h0;
  logic        bus_wr_en = 1'b0;
  logic [1:0]  bus_wr_addr = 2'd0;
  logic [15:0] bus_wr_data = 16'h0;
  logic [1:0]  bus_rd_addr = 2'd0;
  logic [15:0] bus_rd_data, result;
  logic        flag_z, flag_n, flag_c, flag_v, flag_s, flag_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dsp_alu_unit u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .x_sel(x_sel), .y_sel(y_sel), .rbus_in(rbus_in),
    .bus_wr_en(bus_wr_en), .bus_wr_addr(bus_wr_addr), .bus_wr_data(bus_wr_data),
    .bus_rd_addr(bus_rd_addr), .bus_rd_data(bus_rd_data), .result(result),
    .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c), .flag_v(flag_v),
    .flag_s(flag_s), .flag_q(flag_q)
  );

  // {op, x, y, expected result, expected z n c v}
  localparam int NV = 23;
  localparam logic [55:0] VEC [NV] = '{
    {4'd0,  16'h0001, 16'h0002, 16'h0003, 4'b0000},
    {4'd0,  16'h7FFF, 16'h0001, 16'h8000, 4'b0101},
    {4'd0,  16'hFFFF, 16'h0001, 16'h0000, 4'b1010},
    {4'd0,  16'h8000, 16'h8000, 16'h0000, 4'b1011},
    {4'd2,  16'h0005, 16'h0003, 16'h0002, 4'b0010},
    {4'd2,  16'h0003, 16'h0005, 16'hFFFE, 4'b0100},
    {4'd2,  16'h8000, 16'h0001, 16'h7FFF, 4'b0011},
    {4'd3,  16'h0003, 16'h0010, 16'h000D, 4'b0010},
    {4'd4,  16'h0001, 16'h0000, 16'hFFFF, 4'b0100},
    {4'd4,  16'h8000, 16'h0000, 16'h8000, 4'b0101},
    {4'd4,  16'h0000, 16'h0000, 16'h0000, 4'b1010},
    {4'd5,  16'h7FFF, 16'h0000, 16'h8000, 4'b0101},
    {4'd5,  16'hFFFF, 16'h0000, 16'h0000, 4'b1010},
    {4'd6,  16'h0000, 16'h0000, 16'hFFFF, 4'b0100},
    {4'd6,  16'h8000, 16'h0000, 16'h7FFF, 4'b0011},
    {4'd6,  16'h0001, 16'h0000, 16'h0000, 4'b1010},
    {4'd7,  16'hFFFB, 16'h0000, 16'h0005, 4'b0000},
    {4'd7,  16'h8000, 16'h0000, 16'h8000, 4'b0101},
    {4'd7,  16'h0007, 16'h0000, 16'h0007, 4'b0000},
    {4'd8,  16'hF0F0, 16'h3C3C, 16'h3030, 4'b0000},
    {4'd9,  16'hF0F0, 16'h0F00, 16'hFFF0, 4'b0100},
    {4'd10, 16'hAAAA, 16'hAAAA, 16'h0000, 4'b1000},
    {4'd11, 16'h00FF, 16'h0000, 16'hFF00, 4'b0100}
  };

  function automatic string req_of(input logic [3:0] op);
    if (op <= 4'd3) return "R3";
    if (op <= 4'd6) return "R4";
    if (op == 4'd7) return "R6";
    return "R7";
  endfunction

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_wr_addr = a; bus_wr_data = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic do_op(input logic [3:0] op, input logic [1:0] xs, input logic [1:0] ys);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; x_sel = xs; y_sel = ys;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd_addr = a;
    @(negedge clk);
    d = bus_rd_data;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [15:0] rd;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1", "result", result, 16'h0);
    check("R1", "flags", {10'b0, flag_z, flag_n, flag_c, flag_v, flag_s, flag_q}, 16'h0);
    for (int a = 0; a < 4; a++) begin
      bus_read(2'(a), rd);
      check("R1", "operand reg", rd, 16'h0);
    end

    // Table walk: R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [55:0] e;
      e = VEC[i];
      bus_write(2'd0, e[51:36]);
      bus_write(2'd2, e[35:20]);
      do_op(e[55:52], 2'd0, 2'd0);
      check(req_of(e[55:52]), "result", result, e[19:4]);
      check(req_of(e[55:52]), "zncv", {12'b0, flag_z, flag_n, flag_c, flag_v}, {12'b0, e[3:0]});
      if (e[55:52] <= 4'd6)
        check("R5", "overflow", {15'b0, flag_v}, {15'b0, e[0]});
    end

    // R11 bus writes to all four registers, read back
    bus_write(2'd1, 16'h2000);
    bus_write(2'd3, 16'h0003);
    bus_read(2'd1, rd);
    check("R11", "X1 readback", rd, 16'h2000);
    bus_read(2'd3, rd);
    check("R11", "Y1 readback", rd, 16'h0003);

    // R2 operand sources: second registers, result bus, feedback
    do_op(4'd0, 2'd1, 2'd1);
    check("R2", "X1+Y1", result, 16'h2003);
    bus_write(2'd0, 16'h0010);
    bus_write(2'd2, 16'h0001);
    rbus_in = 16'h0100;
    do_op(4'd0, 2'd2, 2'd0);
    check("R2", "rbus+Y0", result, 16'h0101);
    do_op(4'd0, 2'd0, 2'd3);
    check("R2", "X0+feedback", result, 16'h0111);

    // R11 read during an executing operation
    @(negedge clk);
    bus_rd_addr = 2'd1; op_valid = 1'b1; op_code = 4'd0; x_sel = 2'd0; y_sel = 2'd0;
    @(negedge clk);
    op_valid = 1'b0;
    check("R11", "read while computing", bus_rd_data, 16'h2000);
    check("R11", "op result alongside read", result, 16'h0011);

    // R3 add with carry using stored carry
    bus_write(2'd0, 16'hFFFF);
    do_op(4'd0, 2'd0, 2'd0);
    check("R3", "carry set", {15'b0, flag_c}, 16'h1);
    bus_write(2'd0, 16'h0002);
    bus_write(2'd2, 16'h0003);
    do_op(4'd1, 2'd0, 2'd0);
    check("R3", "addc with C=1", result, 16'h0006);
    do_op(4'd1, 2'd0, 2'd0);
    check("R3", "addc with C=0", result, 16'h0005);

    // R10 idle and reserved opcodes hold everything
    held = {10'b0, flag_z, flag_n, flag_c, flag_v, flag_s, flag_q};
    repeat (3) @(negedge clk);
    check("R10", "idle result", result, 16'h0005);
    do_op(4'd14, 2'd0, 2'd0);
    check("R10", "reserved 14 result", result, 16'h0005);
    do_op(4'd15, 2'd0, 2'd0);
    check("R10", "reserved 15 flags", {10'b0, flag_z, flag_n, flag_c, flag_v, flag_s, flag_q}, held);

    // R6 and R12 sign flag
    bus_write(2'd0, 16'hFFFB);
    do_op(4'd7, 2'd0, 2'd0);
    check("R6", "sign flag from X", {15'b0, flag_s}, 16'h1);
    do_op(4'd0, 2'd0, 2'd0);
    check("R12", "sign held over add", {15'b0, flag_s}, 16'h1);
    bus_write(2'd0, 16'h0007);
    do_op(4'd7, 2'd0, 2'd0);
    check("R6", "sign cleared", {15'b0, flag_s}, 16'h0);

    // R8 R9 division steps, positive dividend
    bus_write(2'd0, 16'h0003);
    bus_write(2'd2, 16'h0005);
    do_op(4'd12, 2'd0, 2'd0);
    check("R8", "sign step result", result, 16'h0005);
    check("R8", "sign step q", {15'b0, flag_q}, 16'h0);
    do_op(4'd13, 2'd0, 2'd2);
    check("R9", "step1 result", result, 16'h0007);
    check("R9", "step1 q", {15'b0, flag_q}, 16'h0);
    do_op(4'd13, 2'd0, 2'd2);
    check("R9", "step2 result", result, 16'h000B);

    // R8 R9 negative dividend
    bus_write(2'd2, 16'hFFF0);
    do_op(4'd12, 2'd0, 2'd0);
    check("R8", "sign step q set", {15'b0, flag_q}, 16'h1);
    check("R8", "sign step cv", {14'b0, flag_c, flag_v}, 16'h0);
    do_op(4'd13, 2'd0, 2'd2);
    check("R9", "add step result", result, 16'hFFE4);
    check("R9", "add step q", {15'b0, flag_q}, 16'h1);
    do_op(4'd0, 2'd0, 2'd0);
    check("R12", "q held over add", {15'b0, flag_q}, 16'h1);

    // R1 reset again mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1", "result after reset", result, 16'h0);
    bus_read(2'd0, rd);
    check("R1", "X0 after reset", rd, 16'h0);

    finish_run();
  end

endmodule